// File: doc/BRIEF.md
# I2C Target Address Recognizer

This block is the front end of an I2C target, clocked by a fast system clock. It watches the two bus lines through synchronizers and finds the START, repeated START and STOP conditions. It shifts in the address phase and decides whether to acknowledge. When it accepts an address, it pulls the data line low for the acknowledge clock. The result is driven out only as an open-drain pull enable.

Software-visible configuration is applied through static inputs. There is a set of 7-bit address slots, each with its own enable. There is one 10-bit address with an enable, and a separate enable for the general call. Once the block is addressed for a write, it acknowledges every data byte and hands each byte to the core as a one-cycle strobe. Once it is addressed for a read, it only flags the direction and leaves the data line alone, because read data is produced elsewhere.

When a STOP arrives, the block raises a single event carrying the last accepted address, its kind and its direction. Reserved address patterns and non-matching addresses are dropped silently.

Top module: `i2c_tgt_match`

## Requirements
- R1: A falling data line while the clock line is high starts an address phase. A rising data line while the clock line is high (STOP) releases the data line and clears `selActive` and `selRead`.
- R2: An address byte whose upper seven bits equal an enabled slot is acknowledged. `sdaPullEn` rises after the clock falls following the eighth bit, is high while the clock is high in the ninth bit, and is low again after the clock falls ending the ninth bit.
- R3: A non-matching address is not acknowledged. The block then leaves the data line released, including for any data bytes, until the next START or STOP.
- R4: A first byte whose upper four bits are 0000 or 1111 never matches a 7-bit slot, even when an enabled slot holds that value. This includes the 10-bit header form 11110xx.
- R5: A first byte of 0x00 (the general call) is acknowledged only when `cfgGenCallEn` is 1. Byte 0x01 is never acknowledged as a general call.
- R6: A 10-bit write is a first byte of 11110, then address bits 9:8, then 0, followed by a second byte equal to address bits 7:0. Both bytes are acknowledged. If the second byte differs, it is not acknowledged.
- R7: After a completed 10-bit write addressing, a repeated START with the header carrying direction 1 is acknowledged as a 10-bit read. The same header with no preceding 10-bit write addressing is not acknowledged.
- R8: After an accepted address, `selActive` is 1 and `selRead` equals the direction bit (bit 0 of the first byte, 1 = read). In a read, the block never pulls the data line.
- R9: In a write, every data byte is acknowledged and presented on `rxData`, most significant bit first, with a one-cycle `rxValid`.
- R10: At STOP, if an address was accepted since the previous STOP, `evtValid` pulses for one cycle. `evtAddr` then holds the address: the 7-bit value zero-extended, the 10-bit value, or 0 for the general call. `evtKind` is 0 for 7-bit, 1 for 10-bit and 2 for the general call, and `evtRead` gives the direction. With no accepted address, no event is raised.
- R11: A repeated START restarts the address phase mid-transfer. The event then reports the last accepted address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| sclIn | input | 1 | Raw bus clock line level |
| sdaIn | input | 1 | Raw bus data line level |
| sdaPullEn | output | 1 | 1 pulls the data line low (open-drain enable) |
| cfgAddr7 | input | 7*NUM_ADDR7 | 7-bit address slots; slot g at bits g*7 upward |
| cfgAddr7En | input | NUM_ADDR7 | Per-slot enable |
| cfgAddr10 | input | 10 | 10-bit own address |
| cfgAddr10En | input | 1 | Enable for the 10-bit address |
| cfgGenCallEn | input | 1 | Enable for general call acceptance |
| selActive | output | 1 | Block is currently addressed |
| selRead | output | 1 | Current addressing is a read |
| rxValid | output | 1 | One-cycle strobe for a received write byte |
| rxData | output | 8 | Received write byte |
| evtValid | output | 1 | One-cycle end-of-transfer event |
| evtAddr | output | 10 | Address reported by the event |
| evtKind | output | 2 | 0 = 7-bit, 1 = 10-bit, 2 = general call |
| evtRead | output | 1 | Direction reported by the event |

## Verification
The hardest case to reach from the ports is the 10-bit read. It needs a header, a matching low byte, and then a repeated START with the read header, all in one transfer. It must also be rejected when the same header arrives without that history. The stimulus drives the bus as an open-drain master built from tasks, chaining START, two address bytes and a repeated START without a STOP in between. It then repeats the read header alone after a STOP to confirm that the memory of the earlier write was cleared. The reserved-pattern cases are reached by loading slots with reserved values and switching the 10-bit enable off, so that only the reserved filter can refuse the byte.

// File: rtl/i2c_tgt_pkg.sv
`timescale 1ns/1ps
package i2c_tgt_pkg;
  localparam int BYTE_W   = 8;
  localparam int ADDR7_W  = 7;
  localparam int ADDR10_W = 10;

  typedef enum logic [1:0] {
    KIND_A7    = 2'd0,
    KIND_A10   = 2'd1,
    KIND_GCALL = 2'd2
  } hitKind_e;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_ADDR1 = 3'd1,
    ST_ADDR2 = 3'd2,
    ST_WDATA = 3'd3,
    ST_RDATA = 3'd4
  } tgtState_e;

  // datapath -> control status
  typedef struct packed {
    logic startSeen;
    logic stopSeen;
    logic byteDone;
    logic ackFall;
    logic relFall;
    logic m7Hit;
    logic gcHit;
    logic h10Hit;
    logic lo10Hit;
    logic dirBit;
  } dpStat_t;

  // control -> datapath strobes
  typedef struct packed {
    logic     latchHit;
    hitKind_e hitKind;
    logic     hitRead;
    logic     emitEvt;
    logic     pushRx;
  } ctrlStrb_t;
endpackage

// File: rtl/i2c_tgt_dp.sv
`timescale 1ns/1ps
module i2c_tgt_dp
  import i2c_tgt_pkg::*;
#(
  parameter int NUM_ADDR7   = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic                          sclIn,
  input  logic                          sdaIn,
  input  logic [NUM_ADDR7*ADDR7_W-1:0]  cfgAddr7,
  input  logic [NUM_ADDR7-1:0]          cfgAddr7En,
  input  logic [ADDR10_W-1:0]           cfgAddr10,
  input  logic                          cfgAddr10En,
  input  logic                          cfgGenCallEn,
  input  ctrlStrb_t                     strb,
  output dpStat_t                       stat,
  output logic                          sclLvl,
  output logic                          rxValid,
  output logic [BYTE_W-1:0]             rxData,
  output logic                          evtValid,
  output logic [ADDR10_W-1:0]           evtAddr,
  output logic [1:0]                    evtKind,
  output logic                          evtRead
);
  localparam int FRAME_BITS = BYTE_W + 1;
  localparam int CNT_W      = $clog2(FRAME_BITS);
  localparam logic [CNT_W-1:0] LAST_DATA = CNT_W'(BYTE_W - 1);
  localparam logic [CNT_W-1:0] ACK_POS   = CNT_W'(BYTE_W);

  // ---------------- synchronizers ----------------
  logic [SYNC_STAGES-1:0] sclPipe, sdaPipe;
  for (genvar s = 0; s < SYNC_STAGES; s++) begin : g_sync
    if (s == 0) begin : g_first
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          sclPipe[0] <= 1'b1;
          sdaPipe[0] <= 1'b1;
        end else begin
          sclPipe[0] <= sclIn;
          sdaPipe[0] <= sdaIn;
        end
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          sclPipe[s] <= 1'b1;
          sdaPipe[s] <= 1'b1;
        end else begin
          sclPipe[s] <= sclPipe[s-1];
          sdaPipe[s] <= sdaPipe[s-1];
        end
      end
    end
  end

  logic sclS, sdaS, sclPrev, sdaPrev;
  assign sclS = sclPipe[SYNC_STAGES-1];
  assign sdaS = sdaPipe[SYNC_STAGES-1];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclPrev <= 1'b1;
      sdaPrev <= 1'b1;
    end else begin
      sclPrev <= sclS;
      sdaPrev <= sdaS;
    end
  end

  logic sclRise, sclFall, startDet, stopDet;
  assign sclRise  = sclS & ~sclPrev;
  assign sclFall  = ~sclS & sclPrev;
  assign startDet = sclS & sclPrev & sdaPrev & ~sdaS;
  assign stopDet  = sclS & sclPrev & ~sdaPrev & sdaS;
  assign sclLvl   = sclS;

  // ---------------- bit counter and shifter ----------------
  logic [CNT_W-1:0]  bitCnt;
  logic [BYTE_W-1:0] shReg, byteNow;
  assign byteNow = {shReg[BYTE_W-2:0], sdaS};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bitCnt <= '0;
      shReg  <= '0;
    end else if (startDet || stopDet) begin
      bitCnt <= '0;
    end else if (sclRise) begin
      shReg  <= byteNow;
      bitCnt <= (bitCnt == ACK_POS) ? '0 : bitCnt + 1'b1;
    end
  end

  // ---------------- address matchers ----------------
  logic [NUM_ADDR7-1:0] slotHit;
  for (genvar g = 0; g < NUM_ADDR7; g++) begin : g_slot
    assign slotHit[g] = cfgAddr7En[g] &&
                        (cfgAddr7[g*ADDR7_W +: ADDR7_W] == byteNow[BYTE_W-1:1]);
  end

  logic reservedGrp;
  assign reservedGrp = (byteNow[BYTE_W-1 -: 4] == 4'b0000) ||
                       (byteNow[BYTE_W-1 -: 4] == 4'b1111);

  assign stat.startSeen = startDet;
  assign stat.stopSeen  = stopDet;
  assign stat.byteDone  = sclRise && (bitCnt == LAST_DATA);
  assign stat.ackFall   = sclFall && (bitCnt == ACK_POS);
  assign stat.relFall   = sclFall && (bitCnt == '0);
  assign stat.m7Hit     = (|slotHit) && !reservedGrp;
  assign stat.gcHit     = cfgGenCallEn && (byteNow == '0);
  assign stat.h10Hit    = cfgAddr10En && (byteNow[BYTE_W-1 -: 5] == 5'b11110) &&
                          (byteNow[2:1] == cfgAddr10[ADDR10_W-1 -: 2]);
  assign stat.lo10Hit   = cfgAddr10En && (byteNow == cfgAddr10[BYTE_W-1:0]);
  assign stat.dirBit    = byteNow[0];

  // ---------------- hit capture and event ----------------
  logic                hitValid, hitRead;
  hitKind_e            hitKind;
  logic [ADDR10_W-1:0] hitAddr, newAddr;

  always_comb begin
    unique case (strb.hitKind)
      KIND_A7:  newAddr = {{(ADDR10_W-ADDR7_W){1'b0}}, byteNow[BYTE_W-1:1]};
      KIND_A10: newAddr = cfgAddr10;
      default:  newAddr = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      hitValid <= 1'b0;
      hitRead  <= 1'b0;
      hitKind  <= KIND_A7;
      hitAddr  <= '0;
      evtValid <= 1'b0;
      evtAddr  <= '0;
      evtKind  <= '0;
      evtRead  <= 1'b0;
    end else begin
      evtValid <= 1'b0;
      if (strb.emitEvt) begin
        evtValid <= hitValid;
        hitValid <= 1'b0;
        if (hitValid) begin
          evtAddr <= hitAddr;
          evtKind <= hitKind;
          evtRead <= hitRead;
        end
      end else if (strb.latchHit) begin
        hitValid <= 1'b1;
        hitKind  <= strb.hitKind;
        hitRead  <= strb.hitRead;
        hitAddr  <= newAddr;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxValid <= 1'b0;
      rxData  <= '0;
    end else begin
      rxValid <= strb.pushRx;
      if (strb.pushRx) rxData <= byteNow;
    end
  end
endmodule

// File: rtl/i2c_tgt_ctrl.sv
`timescale 1ns/1ps
module i2c_tgt_ctrl
  import i2c_tgt_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  dpStat_t   stat,
  output ctrlStrb_t strb,
  output logic      sdaPull,
  output logic      selActive,
  output logic      selRead
);
  tgtState_e st, stN;
  logic ackPend, ackN, pullN, w10Ok, w10N, actN, rdN;

  always_comb begin
    stN   = st;
    ackN  = ackPend;
    pullN = sdaPull;
    w10N  = w10Ok;
    actN  = selActive;
    rdN   = selRead;
    strb  = '0;
    if (stat.stopSeen) begin
      stN = ST_IDLE; ackN = 1'b0; pullN = 1'b0; w10N = 1'b0;
      actN = 1'b0; rdN = 1'b0;
      strb.emitEvt = 1'b1;
    end else if (stat.startSeen) begin
      stN = ST_ADDR1; ackN = 1'b0; pullN = 1'b0;
      actN = 1'b0; rdN = 1'b0;
    end else begin
      if (stat.byteDone) begin
        unique case (st)
          ST_ADDR1: begin
            stN  = ST_IDLE;
            w10N = 1'b0;
            if (stat.h10Hit) begin
              if (!stat.dirBit) begin
                stN = ST_ADDR2; ackN = 1'b1;
              end else if (w10Ok) begin
                stN = ST_RDATA; ackN = 1'b1; actN = 1'b1; rdN = 1'b1;
                w10N = 1'b1;
                strb.latchHit = 1'b1; strb.hitKind = KIND_A10; strb.hitRead = 1'b1;
              end
            end else if (stat.gcHit) begin
              stN = ST_WDATA; ackN = 1'b1; actN = 1'b1; rdN = 1'b0;
              strb.latchHit = 1'b1; strb.hitKind = KIND_GCALL;
            end else if (stat.m7Hit) begin
              stN = stat.dirBit ? ST_RDATA : ST_WDATA;
              ackN = 1'b1; actN = 1'b1; rdN = stat.dirBit;
              strb.latchHit = 1'b1; strb.hitKind = KIND_A7; strb.hitRead = stat.dirBit;
            end
          end
          ST_ADDR2: begin
            if (stat.lo10Hit) begin
              stN = ST_WDATA; ackN = 1'b1; actN = 1'b1; rdN = 1'b0; w10N = 1'b1;
              strb.latchHit = 1'b1; strb.hitKind = KIND_A10;
            end else begin
              stN = ST_IDLE;
            end
          end
          ST_WDATA: begin
            ackN = 1'b1;
            strb.pushRx = 1'b1;
          end
          default: ;
        endcase
      end
      if (stat.ackFall && ackPend) pullN = 1'b1;
      if (stat.relFall) begin
        pullN = 1'b0;
        ackN  = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      st        <= ST_IDLE;
      ackPend   <= 1'b0;
      sdaPull   <= 1'b0;
      w10Ok     <= 1'b0;
      selActive <= 1'b0;
      selRead   <= 1'b0;
    end else begin
      st        <= stN;
      ackPend   <= ackN;
      sdaPull   <= pullN;
      w10Ok     <= w10N;
      selActive <= actN;
      selRead   <= rdN;
    end
  end
endmodule

// File: rtl/i2c_tgt_match.sv
`timescale 1ns/1ps
module i2c_tgt_match
  import i2c_tgt_pkg::*;
#(
  parameter int NUM_ADDR7   = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic                          sclIn,
  input  logic                          sdaIn,
  output logic                          sdaPullEn,
  input  logic [NUM_ADDR7*7-1:0]        cfgAddr7,
  input  logic [NUM_ADDR7-1:0]          cfgAddr7En,
  input  logic [9:0]                    cfgAddr10,
  input  logic                          cfgAddr10En,
  input  logic                          cfgGenCallEn,
  output logic                          selActive,
  output logic                          selRead,
  output logic                          rxValid,
  output logic [7:0]                    rxData,
  output logic                          evtValid,
  output logic [9:0]                    evtAddr,
  output logic [1:0]                    evtKind,
  output logic                          evtRead
);
  dpStat_t   dpStat;
  ctrlStrb_t ctrlStrb;
  logic      sclLvl;

  i2c_tgt_dp #(.NUM_ADDR7(NUM_ADDR7), .SYNC_STAGES(SYNC_STAGES)) dp_i (
    .clk(clk), .rstN(rstN), .sclIn(sclIn), .sdaIn(sdaIn),
    .cfgAddr7(cfgAddr7), .cfgAddr7En(cfgAddr7En),
    .cfgAddr10(cfgAddr10), .cfgAddr10En(cfgAddr10En), .cfgGenCallEn(cfgGenCallEn),
    .strb(ctrlStrb), .stat(dpStat), .sclLvl(sclLvl),
    .rxValid(rxValid), .rxData(rxData),
    .evtValid(evtValid), .evtAddr(evtAddr), .evtKind(evtKind), .evtRead(evtRead)
  );

  i2c_tgt_ctrl ctrl_i (
    .clk(clk), .rstN(rstN), .stat(dpStat), .strb(ctrlStrb),
    .sdaPull(sdaPullEn), .selActive(selActive), .selRead(selRead)
  );
endmodule

// File: rtl/i2c_tgt_match_chk.sv
`timescale 1ns/1ps
module i2c_tgt_match_chk
  import i2c_tgt_pkg::*;
(
  input logic    clk,
  input logic    rstN,
  input logic    sdaPullEn,
  input logic    sclLvl,
  input dpStat_t stat,
  input logic    selActive,
  input logic    selRead,
  input logic    rxValid,
  input logic    evtValid
);
  // R2: the acknowledge pull only starts while the clock line is low
  p_ack_on_low_scl_r2: assert property (@(posedge clk) disable iff (!rstN)
    $rose(sdaPullEn) |-> !sclLvl);

  // R1: START or STOP releases the data line on the next cycle
  p_release_at_cond_r1: assert property (@(posedge clk) disable iff (!rstN)
    (stat.startSeen || stat.stopSeen) |=> !sdaPullEn);

  // R1: STOP deselects
  p_stop_deselects_r1: assert property (@(posedge clk) disable iff (!rstN)
    stat.stopSeen |=> (!selActive && !selRead));

  // R10: event only right after a STOP
  p_evt_after_stop_r10: assert property (@(posedge clk) disable iff (!rstN)
    evtValid |-> $past(stat.stopSeen));

  // R10: event is a single-cycle pulse
  p_evt_pulse_r10: assert property (@(posedge clk) disable iff (!rstN)
    evtValid |=> !evtValid);

  // R9: received bytes only while addressed for a write
  p_rx_write_only_r9: assert property (@(posedge clk) disable iff (!rstN)
    rxValid |-> (selActive && !selRead));
endmodule

bind i2c_tgt_match i2c_tgt_match_chk chk_i (
  .clk(clk), .rstN(rstN), .sdaPullEn(sdaPullEn), .sclLvl(sclLvl),
  .stat(dpStat), .selActive(selActive), .selRead(selRead),
  .rxValid(rxValid), .evtValid(evtValid)
);

// File: tb/i2c_tgt_match_tb_top.sv
`timescale 1ns/1ps
module i2c_tgt_match_tb_top;
  localparam int NUM7 = 4;
  localparam int Q    = 10;   // quarter bit period in clocks

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic mScl = 1'b1;
  logic mSda = 1'b1;
  logic sdaPullEn;
  logic sdaLine;
  logic [NUM7*7-1:0] cfgAddr7;
  logic [NUM7-1:0]   cfgAddr7En;
  logic [9:0]        cfgAddr10;
  logic              cfgAddr10En;
  logic              cfgGenCallEn;
  logic              selActive, selRead, rxValid, evtValid, evtRead;
  logic [7:0]        rxData;
  logic [9:0]        evtAddr;
  logic [1:0]        evtKind;

  assign sdaLine = mSda & ~sdaPullEn;

  always #2.5 clk = ~clk;

  i2c_tgt_match #(.NUM_ADDR7(NUM7)) dut_i (
    .clk(clk), .rstN(rstN), .sclIn(mScl), .sdaIn(sdaLine), .sdaPullEn(sdaPullEn),
    .cfgAddr7(cfgAddr7), .cfgAddr7En(cfgAddr7En), .cfgAddr10(cfgAddr10),
    .cfgAddr10En(cfgAddr10En), .cfgGenCallEn(cfgGenCallEn),
    .selActive(selActive), .selRead(selRead), .rxValid(rxValid), .rxData(rxData),
    .evtValid(evtValid), .evtAddr(evtAddr), .evtKind(evtKind), .evtRead(evtRead)
  );

  int checks = 0;
  int fails  = 0;
  bit finished = 0;
  logic [12:0] evQ[$];
  logic [7:0]  rxQ[$];

  task automatic check_eq(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rstN) begin
      if (evtValid) begin
        if (evQ.size() == 0) check_eq("R10 unexpected event", {19'b0, evtAddr, evtKind, evtRead}, 32'hFFFFFFFF);
        else check_eq("R10 event content", {19'b0, evtAddr, evtKind, evtRead}, {19'b0, evQ.pop_front()});
      end
      if (rxValid) begin
        if (rxQ.size() == 0) check_eq("R9 unexpected byte", {24'b0, rxData}, 32'hFFFFFFFF);
        else check_eq("R9 byte content", {24'b0, rxData}, {24'b0, rxQ.pop_front()});
      end
    end
  end

  task automatic qwait();
    repeat (Q) @(negedge clk);
  endtask

  task automatic bus_start();
    mSda = 1'b1; qwait();
    mScl = 1'b1; qwait();
    mSda = 1'b0; qwait();
    mScl = 1'b0; qwait();
  endtask

  task automatic bus_stop();
    mSda = 1'b0; qwait();
    mScl = 1'b1; qwait();
    mSda = 1'b1; qwait();
  endtask

  task automatic xfer_byte(input logic [7:0] b, input bit expAck, input string tag);
    for (int i = 7; i >= 0; i--) begin
      mSda = b[i]; qwait();
      mScl = 1'b1; qwait(); qwait();
      mScl = 1'b0; qwait();
    end
    mSda = 1'b1; qwait();
    mScl = 1'b1; qwait();
    check_eq({tag, " ack level"}, {31'b0, sdaLine}, {31'b0, ~expAck});
    qwait();
    mScl = 1'b0; qwait();
    if (expAck) check_eq({tag, " R2 release after ninth clock"}, {31'b0, sdaPullEn}, 32'h0);
  endtask

  task automatic expect_drained(input string tag);
    qwait(); qwait();
    check_eq({tag, " R10 events drained"}, evQ.size(), 0);
    check_eq({tag, " R9 bytes drained"}, rxQ.size(), 0);
    check_eq({tag, " R1 deselected after STOP"}, {30'b0, selActive, selRead}, 0);
  endtask

  initial begin
    cfgAddr7     = {7'h06, 7'h7A, 7'h2C, 7'h51};
    cfgAddr7En   = 4'hF;
    cfgAddr10    = 10'h2B5;
    cfgAddr10En  = 1'b1;
    cfgGenCallEn = 1'b0;
    repeat (5) @(negedge clk);
    check_eq("R1 reset pull", {31'b0, sdaPullEn}, 0);
    check_eq("R1 reset select", {30'b0, selActive, selRead}, 0);
    check_eq("R10 reset event", {31'b0, evtValid}, 0);
    rstN = 1'b1;
    repeat (5) @(negedge clk);

    // 7-bit write with two data bytes
    bus_start();
    xfer_byte(8'hA2, 1, "R2 slot0 write");
    check_eq("R8 write selected", {30'b0, selActive, selRead}, 32'h2);
    rxQ.push_back(8'h3C); xfer_byte(8'h3C, 1, "R9 data0");
    rxQ.push_back(8'hC5); xfer_byte(8'hC5, 1, "R9 data1");
    evQ.push_back({10'h051, 2'd0, 1'b0});
    bus_stop(); expect_drained("T1");

    // 7-bit read on slot 1
    bus_start();
    xfer_byte(8'h59, 1, "R2 slot1 read");
    check_eq("R8 read selected", {30'b0, selActive, selRead}, 32'h3);
    xfer_byte(8'hFF, 0, "R8 read phase undriven");
    evQ.push_back({10'h02C, 2'd0, 1'b1});
    bus_stop(); expect_drained("T2");

    // unmatched address
    bus_start();
    xfer_byte(8'h20, 0, "R3 unmatched");
    xfer_byte(8'h00, 0, "R3 data after nack");
    check_eq("R3 not selected", {31'b0, selActive}, 0);
    bus_stop(); expect_drained("T3");

    // reserved patterns
    cfgAddr10En = 1'b0;
    bus_start(); xfer_byte(8'hF4, 0, "R4 header vs slot 1111010"); bus_stop();
    bus_start(); xfer_byte(8'h0C, 0, "R4 slot 0000110"); bus_stop();
    cfgAddr10En = 1'b1;
    expect_drained("T4");

    // general call
    bus_start(); xfer_byte(8'h00, 0, "R5 general call disabled"); bus_stop();
    cfgGenCallEn = 1'b1;
    bus_start();
    xfer_byte(8'h00, 1, "R5 general call enabled");
    rxQ.push_back(8'h77); xfer_byte(8'h77, 1, "R5 general call data");
    evQ.push_back({10'h000, 2'd2, 1'b0});
    bus_stop();
    bus_start(); xfer_byte(8'h01, 0, "R5 byte 0x01"); bus_stop();
    cfgGenCallEn = 1'b0;
    expect_drained("T5");

    // 10-bit write
    bus_start();
    xfer_byte(8'hF4, 1, "R6 header");
    xfer_byte(8'hB5, 1, "R6 low byte");
    rxQ.push_back(8'h9E); xfer_byte(8'h9E, 1, "R6 data");
    evQ.push_back({10'h2B5, 2'd1, 1'b0});
    bus_stop(); expect_drained("T6");

    // 10-bit wrong low byte
    bus_start();
    xfer_byte(8'hF4, 1, "R6 header again");
    xfer_byte(8'hB4, 0, "R6 low mismatch");
    xfer_byte(8'h55, 0, "R3 data after low mismatch");
    bus_stop(); expect_drained("T6b");

    // 10-bit read through repeated start
    bus_start();
    xfer_byte(8'hF4, 1, "R7 header write");
    xfer_byte(8'hB5, 1, "R7 low byte");
    bus_start();
    xfer_byte(8'hF5, 1, "R7 read header after Sr");
    check_eq("R7 read selected", {30'b0, selActive, selRead}, 32'h3);
    xfer_byte(8'hFF, 0, "R7 read phase undriven");
    evQ.push_back({10'h2B5, 2'd1, 1'b1});
    bus_stop(); expect_drained("T7");

    // read header with no preceding 10-bit write
    bus_start(); xfer_byte(8'hF5, 0, "R7 read header alone"); bus_stop();
    expect_drained("T7b");

    // repeated start switches target
    bus_start();
    xfer_byte(8'hA2, 1, "R11 first address");
    rxQ.push_back(8'h11); xfer_byte(8'h11, 1, "R11 data");
    bus_start();
    xfer_byte(8'h59, 1, "R11 address after Sr");
    check_eq("R11 read selected", {30'b0, selActive, selRead}, 32'h3);
    evQ.push_back({10'h02C, 2'd0, 1'b1});
    bus_stop(); expect_drained("T8");

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule